// File: doc/BRIEF.md
# Programmable Slot Calendar Table

This block holds a cyclic schedule of up to 64 slots for one lane. Each slot names the device that owns the cycle, as a 4-bit index; the code 13 marks a slot that nobody owns. In run mode a read pointer steps through the active part of the table, one slot per clock, and goes back to slot 0 after the last active slot. The block drives the owner of the current slot and a flag that is high when that slot belongs to a real device.

Software loads a new schedule in a programming session. Raising the program-enable input opens a session. Each write pulse stores a value at a slot index, and the indices are written from 0 upward. Lowering program-enable closes the session and commits the new table. The table is double-banked, so the sequencer keeps reading the old schedule while a session is open. The new schedule takes over at the first wrap after the commit. The active length is taken from the highest index written in the session, and the block reports it back as length minus one.

Top module: `slot_calendar`

## Requirements
- R1: After reset the table holds one idle entry (code 13). `curLen` reads 0, `slotOwner` reads 13 and `slotValid` is low.
- R2: A write pulse (`wrEn` high) is ignored while `pgmEna` is low. It changes neither the table, nor `curLen`, nor the outcome of a later session.
- R3: On the first clock edge at which `pgmEna` is low after having been high, the session commits. From that edge `curLen` equals the highest `wrIdx` written during the session.
- R4: A session with no accepted write commits nothing. `curLen` and the running schedule stay unchanged.
- R5: During a session, and after a commit until the next wrap, the outputs follow the previously committed table. The new table is output from slot 0 on.
- R6: The read pointer advances by one slot every clock and returns to slot 0 after the active last index.
- R7: `slotValid` is high exactly when `slotOwner` is not the idle code 13.
- R8: A written value above 13 (14 or 15) is stored as the idle code 13.
- R9: A session that writes only index 0 with value 13 yields an empty calendar. The output is then idle on every cycle and `curLen` reads 0.
- R10: A bank swap happens only at a wrap edge, when a commit is pending and `pgmEna` was low on that cycle and on the cycle before. If a session is reopened before the swap, the latest commit defines both the table and the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pgmEna | input | 1 | Program enable. High opens a session; the falling level commits it |
| wrEn | input | 1 | Slot write strobe, accepted only while `pgmEna` is high |
| wrIdx | input | 6 | Slot index being written |
| wrVal | input | 4 | Device index for that slot (13 = idle) |
| curLen | output | 6 | Committed length minus one |
| slotOwner | output | 4 | Owner of the current slot |
| slotValid | output | 1 | High when the current slot is owned by a device |

## Verification
The schedule is tried with several tables:
- A four-slot table mixing devices and an idle slot. This separates pointer stepping from wrap handling.
- A six-slot table holding an out-of-range value. This shows whether values are clamped or stored raw.
- A single idle entry. This tells the empty calendar apart from a stalled pointer.

Writes that arrive with program-enable low, and a session with no writes, check that stray strobes leave no trace. Closing a session and reopening it straight away, before the wrap, shows whether the swap is deferred and whether the last commit wins. A reference model in the bench predicts the owner on every cycle and catches any slot that comes too early or too late.

// File: rtl/slot_calendar_pkg.sv
package slot_calendar_pkg;
  localparam int CAL_DEPTH = 64;
  localparam int DEV_W     = 4;
  localparam int IDX_W     = $clog2(CAL_DEPTH);
  localparam int IDLE_CODE = 13;

  typedef logic [IDX_W-1:0] slotIdx_t;
  typedef logic [DEV_W-1:0] devId_t;

  // strobes from control to storage
  typedef struct packed {
    logic     wrStb;
    logic     wrBank;
    slotIdx_t wrIdx;
    devId_t   wrVal;
    logic     rdBank;
    slotIdx_t rdPtr;
  } calStrobe_t;
endpackage

// File: rtl/slot_calendar_ctrl.sv
module slot_calendar_ctrl
  import slot_calendar_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       pgmEna,
  input  logic       wrEn,
  input  slotIdx_t   wrIdx,
  input  devId_t     wrVal,
  output calStrobe_t stb,
  output slotIdx_t   curLen
);
  logic     pgmPrev;
  logic     sessAny;
  logic     pending;
  logic     actBank;
  slotIdx_t sessHigh;
  slotIdx_t lenQ;
  slotIdx_t runLast;
  slotIdx_t rdPtr;

  logic wrAcc;
  logic commit;
  logic atWrap;
  logic swapNow;

  always_comb begin
    wrAcc   = pgmEna & wrEn;
    commit  = pgmPrev & ~pgmEna;
    atWrap  = (rdPtr == runLast);
    swapNow = atWrap & pending & ~pgmEna & ~pgmPrev;
  end

  // session tracking and commit
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pgmPrev  <= 1'b0;
      sessAny  <= 1'b0;
      sessHigh <= '0;
      pending  <= 1'b0;
      lenQ     <= '0;
    end else begin
      pgmPrev <= pgmEna;
      if (wrAcc) begin
        sessAny  <= 1'b1;
        sessHigh <= (!sessAny || wrIdx > sessHigh) ? wrIdx : sessHigh;
      end else if (commit) begin
        sessAny  <= 1'b0;
        sessHigh <= '0;
        if (sessAny) begin
          pending <= 1'b1;
          lenQ    <= sessHigh;
        end
      end
      if (swapNow) pending <= 1'b0;
    end
  end

  // sequencer and bank select
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr   <= '0;
      runLast <= '0;
      actBank <= 1'b0;
    end else begin
      rdPtr <= atWrap ? '0 : slotIdx_t'(rdPtr + 1'b1);
      if (swapNow) begin
        actBank <= ~actBank;
        runLast <= lenQ;
      end
    end
  end

  always_comb begin
    stb.wrStb  = wrAcc;
    stb.wrBank = ~actBank;
    stb.wrIdx  = wrIdx;
    stb.wrVal  = wrVal;
    stb.rdBank = actBank;
    stb.rdPtr  = rdPtr;
  end

  assign curLen = lenQ;
endmodule

// File: rtl/slot_calendar_store.sv
module slot_calendar_store
  import slot_calendar_pkg::*;
#(
  parameter int DEPTH = CAL_DEPTH,
  parameter int IDLE  = IDLE_CODE
) (
  input  logic       clk,
  input  logic       rstN,
  input  calStrobe_t stb,
  output devId_t     slotOwner,
  output logic       slotValid
);
  localparam devId_t IDLE_V = devId_t'(IDLE);
  localparam int NBANK = 2;

  devId_t bankMem [NBANK][DEPTH];
  devId_t wrData;

  assign wrData = (stb.wrVal > IDLE_V) ? IDLE_V : stb.wrVal;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        for (int i = 0; i < DEPTH; i++) bankMem[b][i] <= IDLE_V;
      end else if (stb.wrStb && (stb.wrBank == 1'(b))) begin
        bankMem[b][stb.wrIdx] <= wrData;
      end
    end
  end

  always_comb begin
    slotOwner = bankMem[stb.rdBank][stb.rdPtr];
    slotValid = (slotOwner != IDLE_V);
  end
endmodule

// File: rtl/slot_calendar.sv
module slot_calendar
  import slot_calendar_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             pgmEna,
  input  logic             wrEn,
  input  logic [IDX_W-1:0] wrIdx,
  input  logic [DEV_W-1:0] wrVal,
  output logic [IDX_W-1:0] curLen,
  output logic [DEV_W-1:0] slotOwner,
  output logic             slotValid
);
  calStrobe_t stb;

  slot_calendar_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .pgmEna(pgmEna), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrVal(wrVal), .stb(stb), .curLen(curLen)
  );

  slot_calendar_store #(.DEPTH(CAL_DEPTH), .IDLE(IDLE_CODE)) uStore (
    .clk(clk), .rstN(rstN), .stb(stb),
    .slotOwner(slotOwner), .slotValid(slotValid)
  );
endmodule

// File: rtl/slot_calendar_chk.sv
module slot_calendar_chk
  import slot_calendar_pkg::*;
(
  input logic     clk,
  input logic     rstN,
  input logic     pgmEna,
  input logic     pgmPrev,
  input slotIdx_t curLen,
  input devId_t   slotOwner,
  input logic     slotValid,
  input slotIdx_t rdPtr,
  input logic     rdBank,
  input slotIdx_t runLast
);
  a_r6_step: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr != runLast) |=> (rdPtr == slotIdx_t'($past(rdPtr) + 1'b1)));

  a_r6_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr == runLast) |=> (rdPtr == '0));

  a_r5_swap_at_wrap: assert property (@(posedge clk) disable iff (!rstN)
    (rdPtr != runLast) |=> $stable(rdBank));

  a_r10_hold_in_session: assert property (@(posedge clk) disable iff (!rstN)
    (pgmEna || pgmPrev) |=> $stable(rdBank));

  a_r3_len_at_commit: assert property (@(posedge clk) disable iff (!rstN)
    !(pgmPrev && !pgmEna) |=> $stable(curLen));

  a_r7_valid: assert property (@(posedge clk) disable iff (!rstN)
    slotValid == (slotOwner != devId_t'(IDLE_CODE)));
endmodule

bind slot_calendar slot_calendar_chk uChk (
  .clk(clk), .rstN(rstN), .pgmEna(pgmEna), .pgmPrev(uCtrl.pgmPrev),
  .curLen(curLen), .slotOwner(slotOwner), .slotValid(slotValid),
  .rdPtr(stb.rdPtr), .rdBank(stb.rdBank), .runLast(uCtrl.runLast)
);

// File: tb/tb_slot_calendar.sv
module tb_slot_calendar;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       pgmEna = 1'b0;
  logic       wrEn = 1'b0;
  logic [5:0] wrIdx = '0;
  logic [3:0] wrVal = '0;
  logic [5:0] curLen;
  logic [3:0] slotOwner;
  logic       slotValid;

  slot_calendar dut (
    .clk(clk), .rstN(rstN), .pgmEna(pgmEna), .wrEn(wrEn),
    .wrIdx(wrIdx), .wrVal(wrVal), .curLen(curLen),
    .slotOwner(slotOwner), .slotValid(slotValid)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  bit finished = 0;
  string phase = "R1";
  int expQ[$];

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  // reference model of the requirements
  int mTab[2][64];
  int mBank, mPtr, mRunLast, mCurLen, mHigh;
  bit mPend, mPrev, mAny;

  always @(posedge clk) begin
    bit oPrev, oPend, wrap;
    int oCur;
    if (!rstN) begin
      for (int b = 0; b < 2; b++) for (int i = 0; i < 64; i++) mTab[b][i] = 13;
      mBank = 0; mPtr = 0; mRunLast = 0; mCurLen = 0; mHigh = 0;
      mPend = 0; mPrev = 0; mAny = 0;
    end else begin
      oPrev = mPrev; oPend = mPend; oCur = mCurLen;
      wrap = (mPtr == mRunLast);
      if (pgmEna && wrEn) begin
        mTab[1-mBank][wrIdx] = (wrVal > 13) ? 13 : int'(wrVal);
        mHigh = (!mAny || wrIdx > mHigh) ? int'(wrIdx) : mHigh;
        mAny = 1;
      end else if (oPrev && !pgmEna) begin
        if (mAny) begin mPend = 1; mCurLen = mHigh; end
        mAny = 0; mHigh = 0;
      end
      if (wrap) begin
        mPtr = 0;
        if (oPend && !pgmEna && !oPrev) begin
          mBank = 1 - mBank; mRunLast = oCur; mPend = 0;
        end
      end else mPtr++;
      mPrev = pgmEna;
      expQ.push_back(mTab[mBank][mPtr]);
    end
  end

  // monitor: scoreboard pop and compare
  always @(negedge clk) begin
    int e;
    if (rstN && expQ.size() > 0) begin
      e = expQ.pop_front();
      chk({phase, " owner"}, slotOwner, e);
      chk({phase, " valid R7"}, slotValid, (e != 13) ? 1 : 0);
    end
  end

  task automatic idle(int n);
    repeat (n) begin @(negedge clk); wrEn = 0; end
  endtask
  task automatic openS();
    @(negedge clk); wrEn = 0; pgmEna = 1;
  endtask
  task automatic wr(int i, int v);
    @(negedge clk); wrEn = 1; wrIdx = 6'(i); wrVal = 4'(v);
  endtask
  task automatic closeS();
    @(negedge clk); wrEn = 0; pgmEna = 0;
  endtask

  initial begin
    #(20 * 100000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int cnt;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    chk("R1 len", curLen, 0);
    chk("R1 owner", slotOwner, 13);
    chk("R1 valid", slotValid, 0);
    idle(8);

    phase = "R5 R6 four-slot";
    openS(); wr(0, 2); wr(1, 5); wr(2, 13); wr(3, 7); closeS();
    @(negedge clk);
    chk("R3 len four", curLen, 3);
    idle(20);

    phase = "R2 R4 stray";
    @(negedge clk); wrEn = 1; wrIdx = 6'd9; wrVal = 4'd9;
    idle(3);
    chk("R2 len", curLen, 3);
    openS(); idle(3); closeS(); idle(2);
    chk("R4 len", curLen, 3);
    idle(12);

    phase = "R5 R8 six-slot";
    openS(); wr(0, 1); wr(1, 4); wr(2, 15); wr(3, 0); wr(4, 12); wr(5, 3);
    closeS();
    @(negedge clk);
    chk("R3 len six", curLen, 5);
    idle(20);

    phase = "R10 reopen";
    openS(); wr(0, 6); wr(1, 8); closeS();
    openS(); wr(0, 9); wr(1, 10); wr(2, 11); closeS();
    @(negedge clk);
    chk("R10 len", curLen, 2);
    idle(20);

    phase = "R9 empty";
    openS(); wr(0, 13); closeS();
    @(negedge clk);
    chk("R9 len", curLen, 0);
    idle(10);
    cnt = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (slotValid) cnt++;
    end
    chk("R9 valid count", cnt, 0);

    idle(2);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule